// File: doc/BRIEF.md
# Dual-Channel Sampling Converter Sequencer

This block sits on the host side of a two-channel, simultaneous-sampling 12-bit converter that has a parallel bus. Each conversion starts when the block pulls the active-low start strobe low. The converter's busy flag then rises, and the block waits for it to drop. It then opens one chip-select window that holds two read pulses, so the two results of that conversion arrive back to back.

A select line chooses which input pair the converter returns. The block only moves that line while the start strobe is high and no read is under way. A request made at any other time is held until the next legal moment. After every read, the block keeps the bus quiet for a settling interval before it starts another conversion.

Both captured words leave together with a one-cycle valid pulse and a tag that names the pair. The host either asks for one conversion at a time or holds a continuous-mode input. Every pulse width and interval is a parameter counted in system clock cycles.

Top module: `adc_pair_seq`

## Requirements
- R1: While rst_ni is low, and immediately after it is released, convst_no, cs_no and rd_no are high, valid_o and timeout_o are low, and pair_o is 0.
- R2: In idle, if start_i or cont_i is high and the select gate is ready (R10), convst_no goes low for exactly CONV_LOW_CYC cycles. At no time is convst_no low while cs_no is low.
- R3: busy_i passes through a SYNC_STAGES-flop synchronizer. Once busy has been seen high, cs_no falls in the cycle that starts on the third clock edge after busy_i is first sampled low (default two stages).
- R4: Within one cs_no low window, in order: CS_SETUP_CYC cycles with rd_no high, RD_LOW_CYC cycles with rd_no low, RD_GAP_CYC cycles with rd_no high, RD_LOW_CYC cycles with rd_no low, then one final cycle with rd_no high. rd_no is never low while cs_no is high.
- R5: res0_o holds data_i as sampled at the clock edge that ends the first read pulse. res1_o holds data_i as sampled at the edge that ends the second read pulse.
- R6: valid_o is high for exactly one cycle, the final cycle of the chip-select window. In that cycle tag_o equals pair_o: 0 selects the channel-A pair, 1 selects the channel-B pair.
- R7: After cs_no returns high, convst_no stays high for at least SETTLE_CYC cycles.
- R8: When the settle interval ends, the next conversion starts at once if start_i or cont_i is high and the gate is ready. Otherwise the block returns to idle and waits.
- R9: pair_o follows pair_sel_i only in idle, or while waiting for a conversion whose synchronized busy is still high. A request made during the start pulse, the read window or the settle interval is held until the next such window.
- R10: A conversion starts only when pair_o equals pair_sel_i and at least SEL_SETUP_CYC cycles have passed since pair_o last changed. The falling edge of convst_no therefore comes at least SEL_SETUP_CYC + 1 cycles after a change.
- R11: If the busy wait lasts BUSY_TIMEOUT_CYC cycles without busy falling, timeout_o pulses for one cycle and the block returns to idle with no read and no valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion |
| cont_i | input | 1 | Continuous-mode request |
| pair_sel_i | input | 1 | Requested input pair (0 = A, 1 = B) |
| busy_i | input | 1 | Converter busy flag, asynchronous |
| data_i | input | DW | Converter parallel data bus |
| convst_no | output | 1 | Conversion start strobe, active low |
| cs_no | output | 1 | Chip select, active low |
| rd_no | output | 1 | Read strobe, active low |
| pair_o | output | 1 | Pair-select line to converter |
| valid_o | output | 1 | Both results valid, one cycle |
| res0_o | output | DW | First result of the pair |
| res1_o | output | DW | Second result of the pair |
| tag_o | output | 1 | Pair the results belong to |
| timeout_o | output | 1 | One-cycle busy timeout flag |

## Verification
The bench builds the block with CONV_LOW_CYC=3, CS_SETUP_CYC=2, RD_LOW_CYC=2, RD_GAP_CYC=1, SETTLE_CYC=5, SEL_SETUP_CYC=6 and BUSY_TIMEOUT_CYC=40. The converter model in the bench holds busy for 12 cycles. These short values let one run cover a long sequence of conversions: a single conversion on each pair, a pair change in idle that delays the launch, requests during the busy wait and during the read window, several continuous back-to-back cycles, and a stuck busy that forces the timeout and is followed by a normal conversion. The timeout stays longer than the modelled busy, so the normal conversions never reach it.

// File: rtl/adc_pair_seq_pkg.sv
package adc_pair_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CONV_LOW, ST_WAIT_BUSY, ST_CS_ASSERT, ST_RD1,
    ST_GAP, ST_RD2, ST_CS_RELEASE, ST_SETTLE
  } seq_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/adc_pair_seq_sync.sv
module adc_pair_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/adc_pair_seq_timer.sv
module adc_pair_seq_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/adc_pair_seq_selgate.sv
module adc_pair_seq_selgate #(
  parameter int SETUP = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic open_i,
  output logic pair_o,
  output logic ready_o
);
  localparam int AW = $clog2(SETUP + 1);
  localparam logic [AW-1:0] AGE_MAX = AW'(SETUP);

  logic [AW-1:0] age_q;
  logic          chg;

  assign chg = open_i && (pair_o != req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_o <= 1'b0;
      age_q  <= AGE_MAX;
    end else if (chg) begin
      pair_o <= req_i;
      age_q  <= '0;
    end else if (age_q != AGE_MAX) begin
      age_q  <= age_q + 1'b1;
    end
  end

  assign ready_o = (age_q == AGE_MAX) && (pair_o == req_i);
endmodule

// File: rtl/adc_pair_seq.sv
module adc_pair_seq
  import adc_pair_seq_pkg::*;
#(
  parameter int DW               = 12,
  parameter int CONV_LOW_CYC     = 2,
  parameter int CS_SETUP_CYC     = 1,
  parameter int RD_LOW_CYC       = 2,
  parameter int RD_GAP_CYC       = 1,
  parameter int SETTLE_CYC       = 15,
  parameter int SEL_SETUP_CYC    = 20,
  parameter int BUSY_TIMEOUT_CYC = 250,
  parameter int SYNC_STAGES      = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cont_i,
  input  logic          pair_sel_i,
  input  logic          busy_i,
  input  logic [DW-1:0] data_i,
  output logic          convst_no,
  output logic          cs_no,
  output logic          rd_no,
  output logic          pair_o,
  output logic          valid_o,
  output logic [DW-1:0] res0_o,
  output logic [DW-1:0] res1_o,
  output logic          tag_o,
  output logic          timeout_o
);
  localparam int PH_MAX = max2(max2(CONV_LOW_CYC, CS_SETUP_CYC),
                               max2(max2(RD_LOW_CYC, RD_GAP_CYC), SETTLE_CYC));
  localparam int CW = $clog2(PH_MAX + 1);
  localparam int TW = $clog2(BUSY_TIMEOUT_CYC + 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] ph_val;
  logic          ph_done, busy_s, sel_ready, sel_open, launch;
  logic          saw_busy_q, cap0, cap1, to_fire;
  logic [TW-1:0] wait_q;

  adc_pair_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(busy_i), .q_o(busy_s));

  adc_pair_seq_timer #(.W(CW)) u_timer (
    .clk_i, .rst_ni, .load_i(state_d != state_q), .val_i(ph_val), .done_o(ph_done));

  // select may move only with convst high and no read pending
  assign sel_open = (state_q == ST_IDLE) || (state_q == ST_WAIT_BUSY && busy_s);

  adc_pair_seq_selgate #(.SETUP(SEL_SETUP_CYC)) u_sel (
    .clk_i, .rst_ni, .req_i(pair_sel_i), .open_i(sel_open),
    .pair_o(pair_o), .ready_o(sel_ready));

  assign launch = (start_i || cont_i) && sel_ready;

  always_comb begin
    state_d = state_q;
    ph_val  = '0;
    cap0    = 1'b0;
    cap1    = 1'b0;
    to_fire = 1'b0;
    unique case (state_q)
      ST_IDLE:
        if (launch) begin
          state_d = ST_CONV_LOW; ph_val = CW'(CONV_LOW_CYC - 1);
        end
      ST_CONV_LOW:
        if (ph_done) state_d = ST_WAIT_BUSY;
      ST_WAIT_BUSY:
        if (saw_busy_q && !busy_s) begin
          state_d = ST_CS_ASSERT; ph_val = CW'(CS_SETUP_CYC - 1);
        end else if (wait_q == TW'(BUSY_TIMEOUT_CYC - 1)) begin
          state_d = ST_IDLE; to_fire = 1'b1;
        end
      ST_CS_ASSERT:
        if (ph_done) begin
          state_d = ST_RD1; ph_val = CW'(RD_LOW_CYC - 1);
        end
      ST_RD1:
        if (ph_done) begin
          state_d = ST_GAP; ph_val = CW'(RD_GAP_CYC - 1); cap0 = 1'b1;
        end
      ST_GAP:
        if (ph_done) begin
          state_d = ST_RD2; ph_val = CW'(RD_LOW_CYC - 1);
        end
      ST_RD2:
        if (ph_done) begin
          state_d = ST_CS_RELEASE; cap1 = 1'b1;
        end
      ST_CS_RELEASE: begin
        state_d = ST_SETTLE; ph_val = CW'(SETTLE_CYC - 1);
      end
      ST_SETTLE:
        if (ph_done) begin
          if (launch) begin
            state_d = ST_CONV_LOW; ph_val = CW'(CONV_LOW_CYC - 1);
          end else begin
            state_d = ST_IDLE;
          end
        end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      saw_busy_q <= 1'b0;
      wait_q     <= '0;
      timeout_o  <= 1'b0;
      res0_o     <= '0;
      res1_o     <= '0;
      tag_o      <= 1'b0;
    end else begin
      state_q    <= state_d;
      timeout_o  <= to_fire;
      saw_busy_q <= (state_q == ST_WAIT_BUSY) && (saw_busy_q || busy_s);
      wait_q     <= (state_q == ST_WAIT_BUSY) ? wait_q + 1'b1 : '0;
      if (cap0) res0_o <= data_i;
      if (cap1) begin
        res1_o <= data_i;
        tag_o  <= pair_o;
      end
    end
  end

  assign convst_no = (state_q != ST_CONV_LOW);
  assign cs_no     = !(state_q inside {ST_CS_ASSERT, ST_RD1, ST_GAP, ST_RD2, ST_CS_RELEASE});
  assign rd_no     = !(state_q inside {ST_RD1, ST_RD2});
  assign valid_o   = (state_q == ST_CS_RELEASE);
endmodule

// File: rtl/adc_pair_seq_chk.sv
module adc_pair_seq_chk #(
  parameter int SEL_SETUP_CYC = 20,
  parameter int SETTLE_CYC    = 15
) (
  input logic clk_i,
  input logic rst_ni,
  input logic convst_no,
  input logic cs_no,
  input logic rd_no,
  input logic pair_o,
  input logic valid_o,
  input logic tag_o,
  input logic timeout_o
);
  int unsigned sel_age_c, cs_hi_c;
  logic        pair_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_age_c   <= SEL_SETUP_CYC;
      cs_hi_c     <= SETTLE_CYC;
      pair_prev_q <= 1'b0;
    end else begin
      pair_prev_q <= pair_o;
      if (pair_o != pair_prev_q)            sel_age_c <= 0;
      else if (sel_age_c < SEL_SETUP_CYC)   sel_age_c <= sel_age_c + 1;
      if (!cs_no)                           cs_hi_c <= 0;
      else if (cs_hi_c < SETTLE_CYC)        cs_hi_c <= cs_hi_c + 1;
    end
  end

  p_rd_in_cs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !cs_no);
  p_no_read_in_conv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !convst_no |-> cs_no);
  p_valid_frame_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (!cs_no && rd_no && tag_o == pair_o));
  p_pair_window_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_o != pair_prev_q) |-> (convst_no && cs_no));
  p_sel_setup_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(convst_no) |-> (sel_age_c >= SEL_SETUP_CYC));
  p_settle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(convst_no) |-> (cs_hi_c >= SETTLE_CYC));
  p_timeout_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (cs_no && convst_no && !valid_o));
endmodule

bind adc_pair_seq adc_pair_seq_chk #(
  .SEL_SETUP_CYC(SEL_SETUP_CYC),
  .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .convst_no(convst_no), .cs_no(cs_no),
  .rd_no(rd_no), .pair_o(pair_o), .valid_o(valid_o), .tag_o(tag_o),
  .timeout_o(timeout_o)
);

// File: tb/adc_pair_seq_bench.sv
module adc_pair_seq_bench;
  localparam int DW = 12, CL = 3, CSU = 2, RL = 2, RG = 1, ST = 5, SU = 6, TO = 40;
  localparam int BUSY = 12;
  localparam int T0   = BUSY + 3;               // cycle cs falls (R3)
  localparam int TV   = T0 + CSU + 2*RL + RG;   // valid cycle
  localparam int TEND = TV + 1 + ST;            // first cycle after settle

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic start = 0, cont = 0, psel = 0, busy;
  logic [DW-1:0] data;
  logic convst_no, cs_no, rd_no, pair_o, valid_o, tag_o, timeout_o;
  logic [DW-1:0] res0, res1;

  adc_pair_seq #(
    .DW(DW), .CONV_LOW_CYC(CL), .CS_SETUP_CYC(CSU), .RD_LOW_CYC(RL),
    .RD_GAP_CYC(RG), .SETTLE_CYC(ST), .SEL_SETUP_CYC(SU), .BUSY_TIMEOUT_CYC(TO)
  ) u_adc_pair_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cont_i(cont),
    .pair_sel_i(psel), .busy_i(busy), .data_i(data), .convst_no(convst_no),
    .cs_no(cs_no), .rd_no(rd_no), .pair_o(pair_o), .valid_o(valid_o),
    .res0_o(res0), .res1_o(res1), .tag_o(tag_o), .timeout_o(timeout_o));

  int vecs = 0, fails = 0;

  function automatic logic [DW-1:0] sample_val(input int n, input bit p, input int i);
    logic [DW-1:0] r;
    r = DW'(n*53 + i*1000 + (p ? 700 : 0));
    return p ? (r ^ 12'h800) : r;
  endfunction

  // converter model
  bit adc_stuck = 0;
  int adc_n, bcnt, rdn;
  logic conv_prev, rd_prev;
  always @(negedge clk) begin
    if (!rst_n) begin
      busy = 0; adc_n = 0; rdn = 0; bcnt = 0; conv_prev = 1; rd_prev = 1; data = '0;
    end else begin
      if (conv_prev && !convst_no) begin
        busy = 1; bcnt = BUSY; adc_n++; rdn = 0;
      end else if (busy && !adc_stuck) begin
        bcnt--; if (bcnt == 0) busy = 0;
      end
      if (!rd_prev && rd_no) rdn++;
      data = sample_val(adc_n, pair_o, rdn);
      conv_prev = convst_no; rd_prev = rd_no;
    end
  end

  // reference model: k = cycles since launch, -1 when idle
  int k = -1, age = SU, mn = 0;
  bit ep = 0, mst = 0, etmo = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k = -1; age = SU; mn = 0; ep = 0; mst = 0; etmo = 0;
    end else begin
      bit chg, go, launch, to_idle;
      chg = 0; launch = 0; to_idle = 0;
      go = (start || cont) && age >= SU && ep == psel;
      etmo = 0;
      if (k < 0) begin
        if (ep != psel) chg = 1; else if (go) launch = 1;
      end else if (k >= CL && (mst || k < T0)) begin
        if (mst) begin
          if (ep != psel) chg = 1;
          if (k - CL == TO - 1) begin to_idle = 1; etmo = 1; end
        end else if (k <= T0 - 2 && ep != psel) chg = 1;
      end else if (!mst && k == TEND - 1) begin
        if (go) launch = 1; else to_idle = 1;
      end
      if (chg) begin ep = psel; age = 0; end
      else if (age < SU) age++;
      if (launch) begin k = 0; mn++; mst = adc_stuck; end
      else if (to_idle) k = -1;
      else if (k >= 0) k++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit e_conv, e_cs, e_rd, e_val, act;
    act   = (k >= 0) && !mst;
    e_conv = !(k >= 0 && k < CL);
    e_cs  = !(act && k >= T0 && k <= TV);
    e_rd  = !(act && ((k >= T0+CSU && k < T0+CSU+RL) || (k >= T0+CSU+RL+RG && k < TV)));
    e_val = act && k == TV;
    if (!rst_n) begin
      // R1 reset state
      chk("R1 convst_no", convst_no, 1); chk("R1 cs_no", cs_no, 1);
      chk("R1 rd_no", rd_no, 1); chk("R1 valid_o", valid_o, 0);
      chk("R1 timeout_o", timeout_o, 0); chk("R1 pair_o", pair_o, 0);
    end else begin
      chk("R2 R7 R8 R10 convst_no", convst_no, e_conv);
      chk("R3 R4 cs_no", cs_no, e_cs);
      chk("R4 rd_no", rd_no, e_rd);
      chk("R6 valid_o", valid_o, e_val);
      chk("R11 timeout_o", timeout_o, etmo);
      chk("R9 pair_o", pair_o, ep);
      if (e_val) begin
        chk("R5 res0_o", res0, sample_val(mn, ep, 0));
        chk("R5 res1_o", res1, sample_val(mn, ep, 1));
        chk("R6 tag_o", tag_o, ep);
      end
    end
  end

  bit done = 0;
  task automatic one_shot();
    @(negedge clk); start = 1;
    do @(negedge clk); while (convst_no);
    start = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R2 R3 R4 R5 R6: single conversion on pair A
    one_shot();
    repeat (TEND + 5) @(negedge clk);
    // R10: pair change in idle delays launch
    psel = 1; one_shot();
    repeat (TEND + 5) @(negedge clk);
    // R9: request during start pulse is held, applied during busy wait
    start = 1; @(negedge clk); start = 0;
    repeat (2) @(negedge clk); psel = 0;
    repeat (TEND + SU + 10) @(negedge clk);
    // R8: continuous run, requests inside the read window held
    cont = 1;
    repeat (T0 + 3) @(negedge clk); psel = 1;
    repeat (TEND * 2) @(negedge clk); psel = 0;
    repeat (8) @(negedge clk); psel = 1;
    repeat (TEND * 3) @(negedge clk);
    cont = 0;
    repeat (TEND + SU + 10) @(negedge clk);
    // R11: busy stuck high forces timeout, pair change allowed meanwhile
    adc_stuck = 1; one_shot();
    repeat (CL + 10) @(negedge clk); psel = 0;
    repeat (TO + 10) @(negedge clk);
    adc_stuck = 0;
    repeat (BUSY + 10) @(negedge clk);
    // R8: single mode recovers and returns to idle
    one_shot();
    repeat (TEND + 10) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule